// File: doc/BRIEF.md
# Cycle-Skipping Switch Controller with Auto-Restart

This block is the digital decision core of an on/off-regulated power switch. A free-running oscillator marks the start of each switching cycle and opens a maximum-duty window. On every cycle start the controller looks at the feedback line once. If regulation has not yet been reached, the switch is turned on for that cycle; otherwise the whole cycle is skipped. Output regulation therefore comes from the number of cycles that are enabled, not from the width of each pulse.

While the switch conducts, an over-current flag ends the pulse early. The flag is ignored for a short blanking window after turn-on, so the switching spike at turn-on cannot trip it. The maximum-duty window ending also ends the pulse. Two hysteretic lockouts stop all switching: supply undervoltage, which is treated as active from reset until the supply-good flag is seen, and over-temperature. An auto-restart timer detects that feedback has never asked for a skip over a long run window. It then forces a long off window, and the run and off windows keep alternating until feedback returns.

All inputs are comparator levels already synchronous to the system clock `clk`. Blanking and both restart windows are counted in `clk` cycles.

Top module: `sw_cycle_skip_ctrl`

## Requirements
- R1: The feedback-disable input `fb_dis_i` is used only in the clock where `cyc_clk_i` is high and was low in the clock before (a cycle start). Changes to it at any other time do not affect the gate.
- R2: When a cycle start sees `fb_dis_i` low, `dmax_i` high and no lockout or restart hold active, `gate_o` is high from the next clock. When a cycle start sees `fb_dis_i` high, `gate_o` is low from the next clock until at least the next cycle start.
- R3: While `gate_o` is high and the blanking window has expired, a high `ilim_i` drives `gate_o` low on the next clock, and it stays low for the rest of that cycle.
- R4: For BLANK_CLKS clocks after the clock in which `gate_o` rises, `ilim_i` has no effect on the gate.
- R5: When `dmax_i` is low outside a cycle start, `gate_o` is low on the next clock.
- R6: An undervoltage lockout flag is set by `uv_lo_i` and cleared only by `uv_hi_i`, with set taking priority. It is set out of reset. While it is set, `gate_o` goes low and stays low.
- R7: An over-temperature lockout flag is set by `th_hot_i` and cleared only by `th_cool_i`, with set taking priority. It is clear out of reset. While it is set, `gate_o` goes low and stays low.
- R8: The restart counter is cleared by each cycle start that sees `fb_dis_i` high. If RUN_CLKS clocks pass without such a clear, switching is held off for OFF_CLKS clocks, and feedback is ignored during that time. The counter then restarts from zero in the run state, and the run and off windows alternate while the fault persists.
- R9: While `rst_n` is low and on the first clock after it, `gate_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_clk_i | input | 1 | Oscillator cycle clock level; its rising edge starts a cycle |
| dmax_i | input | 1 | High while the maximum-duty window of the cycle is open |
| fb_dis_i | input | 1 | High when regulation is reached and the cycle is to be skipped |
| ilim_i | input | 1 | Over-current comparator output |
| uv_lo_i | input | 1 | Supply is below the lower undervoltage threshold |
| uv_hi_i | input | 1 | Supply is at or above the upper undervoltage threshold |
| th_hot_i | input | 1 | Die temperature is above the shutdown threshold |
| th_cool_i | input | 1 | Die temperature has fallen below the recovery threshold |
| gate_o | output | 1 | Switch gate drive |

## Verification
The assertions assume that all comparator levels are already synchronous to `clk`. They also assume that the two inputs of a hysteresis pair, `uv_lo_i`/`uv_hi_i` and `th_hot_i`/`th_cool_i`, are never high in the same clock, and that the cycle clock has a period several clocks long with the duty window inside it. The stimulus drives every input on the falling edge from a fixed 16-clock oscillator pattern. The two members of each hysteresis pair are drawn as mutually exclusive events. Feedback and over-current are toggled at random in every clock, so both mid-cycle changes and starts that land on either value occur often.

// File: rtl/sw_ctrl_pkg.sv
// Package: shared definitions for the cycle-skipping switch controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sw_ctrl_pkg;

    // Auto-restart timer phase.
    typedef enum logic {
        AR_RUN  = 1'b0,
        AR_HOLD = 1'b1
    } ar_phase_e;

    // Index of each hysteretic lockout flag in the flag vector.
    localparam int FLT_UV  = 0;
    localparam int FLT_OT  = 1;
    localparam int NUM_FLT = 2;

endpackage

// File: rtl/sw_hyst_flag.sv
// Module: sw_hyst_flag
// A set/clear flag that models comparator hysteresis: one input sets the
// fault and only the other input clears it. Set wins when both are high.
// Assumes set_i and clr_i are synchronous to clk.
module sw_hyst_flag #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the fault state between the set and clear thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= RST_VAL;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);                                            // R6 R7
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);                               // R6 R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));                      // R6 R7

endmodule

// File: rtl/sw_restart_timer.sv
// Module: sw_restart_timer
// Auto-restart timer. In the run phase it counts clocks since the last
// cycle start that saw feedback-disable high. After RUN_CLKS clocks without
// such an event it enters the hold phase for OFF_CLKS clocks, then runs again.
// Assumes RUN_CLKS and OFF_CLKS are at least 2.
module sw_restart_timer
    import sw_ctrl_pkg::*;
#(
    parameter int RUN_CLKS = 5_000_000,
    parameter int OFF_CLKS = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fb_dis_i,
    output logic hold_o
);

    localparam int MAX_CLKS = (RUN_CLKS > OFF_CLKS) ? RUN_CLKS : OFF_CLKS;
    localparam int CW       = $clog2(MAX_CLKS + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(RUN_CLKS - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CLKS - 1);

    ar_phase_e       phase_q;
    logic [CW-1:0]   cnt_q;

    // Advance the run/hold window counter and switch phase at its ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= AR_RUN;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                AR_RUN: begin
                    if (start_i && fb_dis_i) begin
                        cnt_q <= '0;
                    end else if (cnt_q == RUN_LAST) begin
                        phase_q <= AR_HOLD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == OFF_LAST) begin
                        phase_q <= AR_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign hold_o = (phase_q == AR_HOLD);

    AST_HOLD_NOT_AFTER_FB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(!(start_i && fb_dis_i)));             // R8
    AST_FB_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_o && start_i && fb_dis_i) |=> !hold_o);                // R8

endmodule

// File: rtl/sw_gate_ctrl.sv
// Module: sw_gate_ctrl
// Per-cycle gate decision. On a cycle start it latches an on/skip decision
// from feedback, the duty window and the block input. During conduction it
// ends the pulse on block, on the end of the duty window, or on over-current
// once the blanking counter has run out.
// Assumes start_i is a one-clock pulse and BLANK_CLKS >= 1.
module sw_gate_ctrl #(
    parameter int BLANK_CLKS = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic fb_dis_i,
    input  logic dmax_i,
    input  logic ilim_i,
    input  logic block_i,
    output logic gate_o
);

    localparam int BW = $clog2(BLANK_CLKS + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CLKS);

    logic          gate_q;
    logic [BW-1:0] blank_q;
    logic          blank_done;
    logic          cut_now;

    assign blank_done = (blank_q == '0);
    assign cut_now    = block_i || !dmax_i || (ilim_i && blank_done);

    // Decide the gate at cycle start; end conduction on any cut condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            blank_q <= '0;
        end else if (start_i) begin
            gate_q  <= !fb_dis_i && !block_i && dmax_i;
            blank_q <= BLANK_LOAD;
        end else if (gate_q) begin
            if (cut_now)
                gate_q <= 1'b0;
            if (!blank_done)
                blank_q <= blank_q - 1'b1;
        end
    end

    assign gate_o = gate_q;

    AST_ON_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> $past(start_i && !fb_dis_i));               // R1
    AST_SKIP_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && fb_dis_i) |=> !gate_q);                           // R2
    AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_q && !start_i) |=> !gate_q);                           // R3
    AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && blank_done && ilim_i && !start_i) |=> !gate_q);    // R3
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !blank_done && dmax_i && !block_i && !start_i) |=> gate_q); // R4
    AST_DMAX_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmax_i && !start_i) |=> !gate_q);                           // R5
    AST_BLOCK_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> !gate_q);                                         // R8

endmodule

// File: rtl/sw_cycle_skip_ctrl.sv
// Module: sw_cycle_skip_ctrl (top)
// Cycle-skipping switch controller. Detects the start of each oscillator
// cycle, keeps the undervoltage and over-temperature lockout flags, runs
// the auto-restart timer and drives the gate through the per-cycle decision.
// Assumes all inputs are synchronous to clk and the cycle clock is high for
// at least one clk period and low for at least one clk period.
module sw_cycle_skip_ctrl
    import sw_ctrl_pkg::*;
#(
    parameter int BLANK_CLKS = 26,
    parameter int RUN_CLKS   = 5_000_000,
    parameter int OFF_CLKS   = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_clk_i,
    input  logic dmax_i,
    input  logic fb_dis_i,
    input  logic ilim_i,
    input  logic uv_lo_i,
    input  logic uv_hi_i,
    input  logic th_hot_i,
    input  logic th_cool_i,
    output logic gate_o
);

    // Reset value per lockout flag: undervoltage starts active.
    localparam logic [NUM_FLT-1:0] FLT_RST = NUM_FLT'(1) << FLT_UV;

    logic               cyc_q;
    logic               start;
    logic [NUM_FLT-1:0] flt_set;
    logic [NUM_FLT-1:0] flt_clr;
    logic [NUM_FLT-1:0] flt;
    logic               ar_hold;
    logic               block;

    // Remember the cycle clock level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_q <= 1'b0;
        else
            cyc_q <= cyc_clk_i;
    end

    assign start = cyc_clk_i && !cyc_q;

    assign flt_set[FLT_UV] = uv_lo_i;
    assign flt_clr[FLT_UV] = uv_hi_i;
    assign flt_set[FLT_OT] = th_hot_i;
    assign flt_clr[FLT_OT] = th_cool_i;

    for (genvar gi = 0; gi < NUM_FLT; gi++) begin : g_flt
        sw_hyst_flag #(
            .RST_VAL (FLT_RST[gi])
        ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flt_set[gi]),
            .clr_i  (flt_clr[gi]),
            .flag_o (flt[gi])
        );
    end

    sw_restart_timer #(
        .RUN_CLKS (RUN_CLKS),
        .OFF_CLKS (OFF_CLKS)
    ) u_restart (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .fb_dis_i (fb_dis_i),
        .hold_o   (ar_hold)
    );

    assign block = (|flt) || ar_hold;

    sw_gate_ctrl #(
        .BLANK_CLKS (BLANK_CLKS)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .fb_dis_i (fb_dis_i),
        .dmax_i   (dmax_i),
        .ilim_i   (ilim_i),
        .block_i  (block),
        .gate_o   (gate_o)
    );

    AST_UV_LOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        flt[FLT_UV] |=> !gate_o);                                     // R6
    AST_OT_LOCKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        flt[FLT_OT] |=> !gate_o);                                     // R7
    AST_NO_RISE_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(start));                              // R1

endmodule

// File: tb/sw_cycle_skip_ctrl_tb.sv
// Bench: drives a 16-clock oscillator pattern with random feedback,
// over-current and lockout events, and compares gate_o on every clock with
// a behavioural reference model kept in integers.
module sw_cycle_skip_ctrl_tb;

    localparam int BLANK = 3;
    localparam int RUN   = 200;
    localparam int OFF   = 120;
    localparam int PER   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc = 1'b0, dmax = 1'b0, fb_dis = 1'b0, ilim = 1'b0;
    logic uv_lo = 1'b0, uv_hi = 1'b0, th_hot = 1'b0, th_cool = 1'b0;
    logic gate;

    always #4 clk = ~clk;   // 125 MHz

    sw_cycle_skip_ctrl #(
        .BLANK_CLKS (BLANK),
        .RUN_CLKS   (RUN),
        .OFF_CLKS   (OFF)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_clk_i (cyc),
        .dmax_i    (dmax),
        .fb_dis_i  (fb_dis),
        .ilim_i    (ilim),
        .uv_lo_i   (uv_lo),
        .uv_hi_i   (uv_hi),
        .th_hot_i  (th_hot),
        .th_cool_i (th_cool),
        .gate_o    (gate)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string cur_req = "R9";

    // ---------------- reference model ----------------
    int m_cycq, m_uv, m_ot, m_hold, m_cnt, m_gate, m_blank;
    int st, blk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cycq = 0; m_uv = 1; m_ot = 0; m_hold = 0;
            m_cnt = 0; m_gate = 0; m_blank = 0;
        end else begin
            st  = (cyc && m_cycq == 0) ? 1 : 0;
            blk = (m_uv != 0 || m_ot != 0 || m_hold != 0) ? 1 : 0;
            // gate decision for this clock
            if (st != 0) begin
                m_gate  = (!fb_dis && blk == 0 && dmax) ? 1 : 0;
                m_blank = BLANK;
            end else if (m_gate != 0) begin
                if (blk != 0 || !dmax || (ilim && m_blank == 0)) m_gate = 0;
                if (m_blank > 0) m_blank = m_blank - 1;
            end
            // restart windows
            if (m_hold == 0) begin
                if (st != 0 && fb_dis) m_cnt = 0;
                else if (m_cnt == RUN - 1) begin m_hold = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == OFF - 1) begin m_hold = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            // hysteresis flags
            if (uv_lo) m_uv = 1; else if (uv_hi) m_uv = 0;
            if (th_hot) m_ot = 1; else if (th_cool) m_ot = 0;
            m_cycq = cyc ? 1 : 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit pct(input int p);
        return ($urandom_range(99) < p);
    endfunction

    int ph = 0;
    int fb_p = 0, il_p = 0, ul_p = 0, uh_p = 0, hot_p = 0, cool_p = 0;
    int highs = 0, low_run = 0, max_low = 0;

    // One clock: compare at the falling edge, then drive the next inputs.
    task automatic step();
        @(negedge clk);
        check(cur_req, int'(gate), m_gate);
        if (gate) begin highs++; low_run = 0; end
        else begin low_run++; if (low_run > max_low) max_low = low_run; end
        ph      = (ph + 1) % PER;
        cyc     = (ph < 4);
        dmax    = (ph < 11);
        fb_dis  = pct(fb_p);
        ilim    = pct(il_p);
        uv_lo   = pct(ul_p);
        uv_hi   = !uv_lo && pct(uh_p);
        th_hot  = pct(hot_p);
        th_cool = !th_hot && pct(cool_p);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_mode(input int f, input int il, input int ul, input int uh,
                            input int h, input int c);
        fb_p = f; il_p = il; ul_p = ul; uh_p = uh; hot_p = h; cool_p = c;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        set_mode(0, 0, 0, 0, 0, 0);
        repeat (5) @(negedge clk);
        check("R9 reset", int'(gate), 0);
        rst_n = 1'b1;
        cur_req = "R9";
        step();
        check("R9 first clock", int'(gate), 0);

        // R6: undervoltage active from reset until the supply-good flag
        cur_req = "R6";
        highs = 0;
        run(100);
        check("R6 no switching before uv_hi", highs, 0);

        // R1 R2 R5: normal cycle skipping with feedback toggling mid-cycle
        uv_hi = 1'b1; step(); uv_hi = 1'b0;
        cur_req = "R1 R2 R5";
        set_mode(30, 0, 0, 0, 0, 0);
        highs = 0;
        run(1500);
        check("R2 gate switched", int'(highs > 0), 1);

        // R3 R4: over-current with blanking
        cur_req = "R3 R4";
        set_mode(30, 25, 0, 0, 0, 0);
        run(1500);

        // R6: undervoltage events with hysteresis
        cur_req = "R6";
        set_mode(30, 10, 1, 3, 0, 0);
        run(2000);

        // R7: directed thermal lockout and recovery
        set_mode(30, 0, 0, 0, 0, 0);
        uv_hi = 1'b1; step(); uv_hi = 1'b0;
        cur_req = "R7";
        th_hot = 1'b1; step(); th_hot = 1'b0;
        highs = 0;
        run(64);
        check("R7 off while hot", highs, 0);
        th_cool = 1'b1; step(); th_cool = 1'b0;
        set_mode(10, 0, 0, 0, 0, 0);
        highs = 0;
        run(64);
        check("R7 back after cool", int'(highs > 0), 1);

        // R7: random thermal events
        set_mode(30, 10, 0, 0, 1, 3);
        run(2000);

        // R8: feedback never skips a cycle -> auto-restart windows
        set_mode(0, 0, 0, 0, 0, 0);
        th_cool = 1'b1; uv_hi = 1'b1; step(); th_cool = 1'b0; uv_hi = 1'b0;
        cur_req = "R8";
        highs = 0; max_low = 0; low_run = 0;
        run(1200);
        check("R8 hold window length", int'(max_low >= OFF), 1);
        check("R8 run window switches", int'(highs > 0), 1);

        // R8: feedback returns, normal cycles resume
        set_mode(30, 5, 0, 0, 0, 0);
        highs = 0;
        run(1500);
        check("R8 recovery", int'(highs > 0), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all R1..): actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule